// File: doc/BRIEF.md
# Page-Safe Burst Write Engine

This block is the write side of a memory-mapped DMA master. A one-cycle start pulse gives it a byte start address and a length counted in data words. It then moves that many words from a valid/ready input stream onto an AXI4 write channel. When a build parameter enables it, a global base address is added to the requested address. The sum is aligned down to the data-bus byte width, which gives the first burst address.

The transfer is cut into bursts. Each burst is the longest one allowed by three limits: the words still to send, the maximum burst length (2 to the power of `BURST_SZ_W` beats), and the words left before the next 4096-byte page edge. One burst is in flight at a time. The engine sends the address request, then forwards the stream beats onto the W channel and flags the final beat with WLAST. It then waits for the write response. After the response it re-sizes the next burst from the advanced address. When nothing remains, it raises `idle` again.

The controller is a six-state machine:
- `ST_IDLE` waits for start. It moves to `ST_CHECK`, or to `ST_DONE` for a zero length.
- `ST_CHECK` picks the burst length and moves to `ST_ADDR`.
- `ST_ADDR` holds AWVALID until AWREADY, then moves to `ST_DATA`.
- `ST_DATA` forwards beats until the last one is accepted, then moves to `ST_RESP`.
- `ST_RESP` holds BREADY until BVALID. It then returns to `ST_CHECK` if words remain, otherwise it moves to `ST_DONE`.
- `ST_DONE` sets `idle` and returns to `ST_IDLE`.

Top module: `wr_burst_dma`

## Requirements
- R1: After reset, `idle` is 1 and `m_awvalid`, `m_wvalid` and `m_bready` are 0.
- R2: The first burst address is (`base_addr` + `start_addr`) modulo 2^ADDR_W, with its low log2(DATA_W/8) bits cleared. The base term is present when `USE_BASE` = 1.
- R3: No burst has more than 2^BURST_SZ_W beats, and `m_awlen` equals the burst's beat count minus one.
- R4: Each burst length is the smallest of three values: the words remaining, 2^BURST_SZ_W, and (4096 − (address mod 4096)) / (DATA_W/8). No burst therefore crosses a 4096-byte page edge.
- R5: Each following burst address is the previous address plus the previous beat count times DATA_W/8, modulo 2^ADDR_W. The beat counts add up to the requested size. AWADDR and AWLEN are held while AWVALID waits for AWREADY.
- R6: W beats carry the stream words in arrival order, and `s_ready` follows `m_wready` during the data phase. WLAST is 1 on the final beat of every burst and 0 on every other beat.
- R7: A new address request is issued only after the previous burst's B handshake. While BREADY is high, neither AWVALID nor WVALID is high.
- R8: `idle` goes to 0 on the cycle after an accepted start and returns to 1 after the final response. A start with size 0 issues no burst and returns to idle.
- R9: A start pulse while `idle` is 0 is ignored. This includes the cycle in which the last response has just completed. Such a pulse causes no extra burst and leaves the running transfer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle transfer request |
| start_addr | input | ADDR_W | Byte start address |
| start_size | input | ADDR_W+1 | Transfer length in words |
| base_addr | input | ADDR_W | Global base added when USE_BASE = 1 |
| idle | output | 1 | High when no transfer is running |
| s_data | input | DATA_W | Input stream word |
| s_valid | input | 1 | Input stream valid |
| s_ready | output | 1 | Input stream ready |
| m_awaddr | output | ADDR_W | Burst byte address |
| m_awlen | output | 8 | Beats in burst minus one |
| m_awvalid | output | 1 | Address request valid |
| m_awready | input | 1 | Address request accepted |
| m_wdata | output | DATA_W | Write data |
| m_wlast | output | 1 | Final beat of burst |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data accepted |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response accepted |

## Verification
Two events can fall in the same cycle, and the bench forces each of them.

The first is a burst length where two of the three limits agree. The page limit and the maximum-length limit can both give the same length, and the remaining-size limit can tie with either of them. Start addresses sit a few words below a page edge, at the top of the address space, and on aligned and unaligned offsets. Sizes sweep from 0 to 9, so the sweep reaches every such tie. Each burst is compared with a greedy split computed in the bench.

The second is a start pulse that coincides with activity. It is driven in the cycle right after an accepted start. It is also driven in the cycle that follows the final B handshake, when the engine is finishing but not yet idle. In both cases the bench checks that no burst appears beyond the computed list and that `idle` settles high.

// File: rtl/wdma_pkg.sv
package wdma_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_ADDR,
        ST_DATA,
        ST_RESP,
        ST_DONE
    } wdma_state_e;
endpackage

// File: rtl/wdma_burst_sizer.sv
module wdma_burst_sizer #(
    parameter int ADDR_W     = 32,
    parameter int SIZE_W     = 33,
    parameter int OFF_W      = 3,
    parameter int BURST_SZ_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] rest,
    output logic [SIZE_W-1:0] burst_len
);
    localparam int PAGE_W = 12;
    localparam logic [SIZE_W-1:0] MAX_BEATS = SIZE_W'(1) << BURST_SZ_W;

    logic [PAGE_W:0]   room_bytes;
    logic [SIZE_W-1:0] room_words;
    logic [SIZE_W-1:0] cap;

    assign room_bytes = (PAGE_W+1)'(1 << PAGE_W) - {1'b0, addr[PAGE_W-1:0]};
    assign room_words = SIZE_W'(room_bytes >> OFF_W);

    always_comb begin
        cap       = (MAX_BEATS < room_words) ? MAX_BEATS : room_words;
        burst_len = (rest < cap) ? rest : cap;
    end
endmodule

// File: rtl/wdma_beat_counter.sv
module wdma_beat_counter #(
    parameter int SIZE_W = 33
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic [SIZE_W-1:0] limit,
    output logic              last
);
    logic [SIZE_W-1:0] count;

    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            count <= '0;
        else if (step)
            count <= count + SIZE_W'(1);
    end

    assign last = (count == limit - SIZE_W'(1));
endmodule

// File: rtl/wr_burst_dma.sv
module wr_burst_dma
    import wdma_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 64,
    parameter int BURST_SZ_W = 8,
    parameter bit USE_BASE   = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [ADDR_W-1:0]   start_addr,
    input  logic [ADDR_W:0]     start_size,
    input  logic [ADDR_W-1:0]   base_addr,
    output logic                idle,
    input  logic [DATA_W-1:0]   s_data,
    input  logic                s_valid,
    output logic                s_ready,
    output logic [ADDR_W-1:0]   m_awaddr,
    output logic [7:0]          m_awlen,
    output logic                m_awvalid,
    input  logic                m_awready,
    output logic [DATA_W-1:0]   m_wdata,
    output logic                m_wlast,
    output logic                m_wvalid,
    input  logic                m_wready,
    input  logic                m_bvalid,
    output logic                m_bready
);
    localparam int SIZE_W = ADDR_W + 1;
    localparam int BYTES  = DATA_W / 8;
    localparam int OFF_W  = $clog2(BYTES);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(BYTES - 1);

    wdma_state_e       state, nxt;
    logic [ADDR_W-1:0] cur_addr;
    logic [SIZE_W-1:0] rest;
    logic [SIZE_W-1:0] cur_size;
    logic [SIZE_W-1:0] burst_len;
    logic [ADDR_W-1:0] eff_addr;
    logic              beat_last;
    logic              w_hs;

    generate
        if (USE_BASE) begin : g_base
            assign eff_addr = start_addr + base_addr;
        end else begin : g_nobase
            assign eff_addr = start_addr;
        end
    endgenerate

    wdma_burst_sizer #(
        .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .OFF_W(OFF_W), .BURST_SZ_W(BURST_SZ_W)
    ) i_sizer (
        .addr(cur_addr), .rest(rest), .burst_len(burst_len)
    );

    wdma_beat_counter #(.SIZE_W(SIZE_W)) i_beats (
        .clk(clk), .rst_n(rst_n), .clear(state == ST_ADDR),
        .step(w_hs), .limit(cur_size), .last(beat_last)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start) nxt = (start_size == '0) ? ST_DONE : ST_CHECK;
            ST_CHECK: nxt = ST_ADDR;
            ST_ADDR:  if (m_awready) nxt = ST_DATA;
            ST_DATA:  if (w_hs && beat_last) nxt = ST_RESP;
            ST_RESP:  if (m_bvalid) nxt = (rest != '0) ? ST_CHECK : ST_DONE;
            ST_DONE:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // datapath and output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            rest     <= '0;
            cur_size <= '0;
            idle     <= 1'b1;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    cur_addr <= eff_addr & ALIGN_MASK;
                    rest     <= start_size;
                    idle     <= 1'b0;
                end
                ST_CHECK: begin
                    cur_size <= burst_len;
                    rest     <= rest - burst_len;
                end
                ST_RESP: if (m_bvalid)
                    cur_addr <= cur_addr + ADDR_W'(cur_size << OFF_W);
                ST_DONE: idle <= 1'b1;
                default: ;
            endcase
        end
    end

    assign m_awvalid = (state == ST_ADDR);
    assign m_awaddr  = cur_addr;
    assign m_awlen   = 8'(cur_size - SIZE_W'(1));
    assign m_wvalid  = (state == ST_DATA) && s_valid;
    assign s_ready   = (state == ST_DATA) && m_wready;
    assign m_wdata   = s_data;
    assign m_wlast   = (state == ST_DATA) && beat_last;
    assign w_hs      = m_wvalid && m_wready;
    assign m_bready  = (state == ST_RESP);

    initial begin
        assert (BURST_SZ_W <= 8 && ADDR_W >= 13 && BYTES >= 2);
    end

    AST_AWLEN_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        m_awvalid |-> (32'(m_awlen) < (32'(1) << BURST_SZ_W)));  // R3

    AST_NO_PAGE_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
        m_awvalid |-> ((32'(m_awaddr[11:0]) + ((32'(m_awlen) + 32'd1) << OFF_W)) <= 32'd4096));  // R4

    AST_AW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (m_awvalid && !m_awready) |=> (m_awvalid && $stable(m_awaddr) && $stable(m_awlen)));  // R5

    AST_LAST_ENDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (m_wvalid && m_wready && m_wlast) |=> !m_wvalid);  // R6

    AST_RESP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        m_bready |-> (!m_awvalid && !m_wvalid));  // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (!m_awvalid && !m_wvalid && !m_bready));  // R8

    AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !idle && state != ST_RESP) |=> $stable(m_awaddr));  // R9
endmodule

// File: tb/test_wr_burst_dma.sv
module test_wr_burst_dma;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int BSW = 2;
    localparam int MAXB = 1 << BSW;
    localparam int BY = DW / 8;

    logic clk = 0, rst_n = 0, start = 0;
    logic [AW-1:0] start_addr = 0, base_addr = 0;
    logic [AW:0] start_size = 0;
    logic idle, s_ready, s_valid = 0;
    logic [DW-1:0] s_data = 0;
    logic [AW-1:0] m_awaddr;
    logic [7:0] m_awlen;
    logic m_awvalid, m_awready = 0;
    logic [DW-1:0] m_wdata;
    logic m_wlast, m_wvalid, m_wready = 0;
    logic m_bvalid = 0, m_bready;

    wr_burst_dma #(.ADDR_W(AW), .DATA_W(DW), .BURST_SZ_W(BSW), .USE_BASE(1'b1)) i_wr_burst_dma (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .start_size(start_size), .base_addr(base_addr), .idle(idle),
        .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
        .m_awaddr(m_awaddr), .m_awlen(m_awlen), .m_awvalid(m_awvalid), .m_awready(m_awready),
        .m_wdata(m_wdata), .m_wlast(m_wlast), .m_wvalid(m_wvalid), .m_wready(m_wready),
        .m_bvalid(m_bvalid), .m_bready(m_bready)
    );

    always #2 clk = ~clk;  // 250 MHz

    int n_chk = 0, n_bad = 0;
    int cyc = 0, mode = 0;
    int exp_addr[16], exp_len[16], n_exp = 0;
    int aw_i = 0, beats = 0, beat_in = 0, pend = 0, b_cnt = 0;
    bit last_b = 0;
    localparam int SEED = 32'h5A00;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // responder and monitor
    always @(negedge clk) begin
        cyc++;
        m_awready = (mode != 0) ? (cyc % 3 != 0) : 1'b1;
        m_wready  = (mode != 0) ? (cyc % 4 != 2) : 1'b1;
        s_valid   = (mode != 0) ? (cyc % 5 != 3) : 1'b1;
        m_bvalid  = (pend > 0) && ((mode != 0) ? (cyc % 2 == 0) : 1'b1);
        s_data    = DW'(SEED + beats);
        #1;
        if (rst_n && m_awvalid && m_awready) begin
            chk(pend == 0, "R7 AW before response", pend, 0);
            if (aw_i >= n_exp) chk(0, "R9 extra burst", aw_i, n_exp);
            else begin
                chk(int'(m_awaddr) == exp_addr[aw_i], (aw_i == 0) ? "R2 first addr" : "R5 next addr",
                    int'(m_awaddr), exp_addr[aw_i]);
                chk(int'(m_awlen) + 1 == exp_len[aw_i], "R3 R4 burst length",
                    int'(m_awlen) + 1, exp_len[aw_i]);
            end
            aw_i++;
            beat_in = 0;
        end
        if (rst_n && m_wvalid && m_wready) begin
            chk(s_ready == 1'b1, "R6 s_ready", s_ready, 1);
            chk(int'(m_wdata) == SEED + beats, "R6 data order", int'(m_wdata), SEED + beats);
            if (aw_i == 0 || aw_i > n_exp) chk(0, "R6 beat without burst", aw_i, n_exp);
            else chk(m_wlast == (beat_in == exp_len[aw_i-1] - 1), "R6 wlast",
                     m_wlast, (beat_in == exp_len[aw_i-1] - 1));
            beats++;
            beat_in++;
            if (m_wlast) pend++;
        end
        if (rst_n && m_bvalid && m_bready) begin
            pend--;
            b_cnt++;
            if (b_cnt == n_exp) last_b = 1;
        end
    end

    task automatic plan(input int base, input int addr, input int size);
        int a = ((base + addr) & 32'hFFFF) & ~(BY - 1);
        int r = size;
        n_exp = 0;
        while (r > 0) begin
            int room = (4096 - (a % 4096)) / BY;
            int c = r;
            if (c > MAXB) c = MAXB;
            if (c > room) c = room;
            exp_addr[n_exp] = a;
            exp_len[n_exp] = c;
            n_exp++;
            r -= c;
            a = (a + c * BY) & 32'hFFFF;
        end
    endtask

    task automatic run(input int base, input int addr, input int size, input bit early, input bit late);
        bit done = 0, injected = 0;
        plan(base, addr, size);
        aw_i = 0; beats = 0; pend = 0; b_cnt = 0; last_b = 0;
        @(negedge clk);
        base_addr = AW'(base); start_addr = AW'(addr); start_size = (AW+1)'(size);
        start = 1;
        @(negedge clk);
        chk(idle == 1'b0, "R8 idle drops", idle, 0);
        start = early;
        start_addr = 16'h0100;
        start_size = 3;
        for (int t = 0; t < 600 && !done; t++) begin
            @(negedge clk);
            start = 0;
            if (late && last_b && !injected) begin
                start = 1;
                injected = 1;
            end else if (idle) done = 1;
        end
        start = 0;
        chk(done, "R8 watchdog idle", done, 1);
        repeat (8) @(negedge clk);
        chk(aw_i == n_exp, "R9 R5 burst count", aw_i, n_exp);
        chk(beats == size, "R5 total beats", beats, size);
        chk(idle == 1'b1, "R9 idle after", idle, 1);
    endtask

    initial begin
        int bases[3] = '{0, 16'h0FF0, 16'hFFF0};
        int addrs[5] = '{16'h0000, 16'h0FF4, 16'h0FFA, 16'h1FFC, 16'h0008};
        int k = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(idle == 1'b1, "R1 idle", idle, 1);
        chk(!m_awvalid && !m_wvalid && !m_bready, "R1 quiet", {m_awvalid, m_wvalid, m_bready}, 0);
        foreach (bases[b]) foreach (addrs[a]) for (int s = 0; s <= 9; s++) begin
            mode = k % 2;
            run(bases[b], addrs[a], s, (k % 3 == 1), (k % 4 == 3) && (s > 0));
            k++;
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #700000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule